// File: doc/BRIEF.md
# Exp-Golomb Syntax Element Decoder

This block turns one Exp-Golomb codeword at the head of a bitstream window into a syntax element value. A leading-one detector upstream supplies the number of zeros in front of the first '1'. The block reads the suffix that follows that '1' and forms the code number. It then maps the code number to an unsigned, signed or truncated value. It also returns the number of bits the codeword occupied, so the bitstream buffer can skip past it.

The window is presented with its first bitstream bit in the most significant position. A codeword with M leading zeros has a '1' after them and then an M-bit suffix, 2M+1 bits in all. A request is made by raising `start` for one cycle with the window, the zero count, the mode and the truncation range held valid. The result registers load on the next clock edge, and `done` pulses for that one cycle. When no request arrives, the results hold their last values.

Top module: `expg_decode`

## Requirements
- R1: In unsigned mode (`mode` = 0, and also `mode` = 3) `value` equals 2^M − 1 + INFO. Here M is `lz`, and INFO is the M window bits that follow the leading '1', read as an unsigned number with the first bitstream bit as its most significant bit.
- R2: For every valid codeword outside truncated range-1 mode, `len` equals 2M+1. It is therefore odd and never larger than 31.
- R3: In signed mode (`mode` = 1) an odd code number k gives +(k+1)/2 and an even one gives −k/2, as a 32-bit two's-complement number. The sequence runs 0, 1, −1, 2, −2 and so on.
- R4: In truncated mode (`mode` = 2) with `trange` = 1, the codeword is the single bit `win[31]`. `value` is the inverse of that bit, `len` is 1 and `err` is 0, whatever `lz` holds.
- R5: In truncated mode with `trange` other than 1, the result equals the unsigned result of R1 and R2.
- R6: When `lz` exceeds 15, or the window bit at position `lz` counted from the MSB is not '1', `err` is 1 and both `value` and `len` are 0.
- R7: `done` is high in exactly the cycle after a cycle with `start` high. `value`, `len` and `err` change only on such a cycle and hold otherwise.
- R8: After reset, `done`, `err`, `len` and `value` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe; the inputs below are sampled while it is high |
| win | input | 32 | Bitstream window; bit 31 is the first bit |
| lz | input | 5 | Leading-zero count M from the leading-one detector |
| mode | input | 2 | 0 unsigned, 1 signed, 2 truncated, 3 unsigned |
| trange | input | 32 | Upper limit of the truncated syntax element |
| value | output | 32 | Decoded syntax element value |
| len | output | 6 | Bits consumed by the codeword; 0 on error |
| err | output | 1 | Codeword was not decodable |
| done | output | 1 | Result valid, one-cycle pulse |

## Verification
The bench builds each codeword from a chosen code number, so the suffix extraction is tested against values the bench chose itself. It covers the smallest and largest code number for every prefix length from 0 to 15. A design with a wrong suffix shift or an off-by-one in 2^M − 1 would fail at the M = 0 or M = 15 edges. Those edges are also where a wrong shift most easily reads the pad bits that follow the codeword.

Signed mapping is run on both odd and even code numbers, so a swapped sign or a missing +1 would show up. Truncated range-1 is given a bogus `lz` to show that the prefix count is ignored. The error cases, an oversized `lz` and a count that does not land on a '1', catch a design that reports a nonzero length and would make the buffer skip bits it never decoded. Idle cycles check that `done` stays low and the results do not drift.

// File: rtl/expg_decode.sv
module expg_decode #(
  parameter int WIN_W = 32,
  parameter int LZ_W  = 5,
  parameter int MAX_M = 15,
  parameter int VAL_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIN_W-1:0] win,
  input  logic [LZ_W-1:0]  lz,
  input  logic [1:0]       mode,
  input  logic [VAL_W-1:0] trange,
  output logic [VAL_W-1:0] value,
  output logic [LEN_W-1:0] len,
  output logic             err,
  output logic             done
);
  localparam int SUF_W = MAX_M;

  logic [WIN_W-1:0] probe, past_one;
  logic [SUF_W-1:0] suf_raw;
  logic [VAL_W-1:0] info, code_num, half_up, sval, mapped;
  logic             m_ok, lead_bit, bad, trunc1;
  logic [LEN_W-1:0] len_c;

  assign m_ok     = (int'(lz) <= MAX_M);
  assign probe    = win << lz;
  assign lead_bit = probe[WIN_W-1];
  assign past_one = probe << 1;
  assign suf_raw  = past_one[WIN_W-1 -: SUF_W];
  assign info     = m_ok ? (VAL_W'(suf_raw) >> (SUF_W - int'(lz))) : '0;
  assign code_num = (VAL_W'(1) << lz) - VAL_W'(1) + info;
  assign half_up  = (code_num + VAL_W'(1)) >> 1;
  assign sval     = code_num[0] ? half_up : -(code_num >> 1);
  assign trunc1   = (mode == 2'd2) && (trange == VAL_W'(1));
  assign bad      = !trunc1 && (!m_ok || !lead_bit);
  assign len_c    = LEN_W'({lz, 1'b1});

  always_comb begin
    if (trunc1)           mapped = VAL_W'(!win[WIN_W-1]);
    else if (mode == 2'd1) mapped = sval;
    else                  mapped = code_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      len   <= '0;
      err   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        err   <= bad;
        value <= bad ? '0 : mapped;
        len   <= bad ? '0 : (trunc1 ? LEN_W'(1) : len_c);
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R7
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> ($stable(value) && $stable(len) && $stable(err))); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> (len == '0 && value == '0)); // R6
  AST_LEN_ODD: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> len[0]); // R2
  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (int'(len) <= 2*MAX_M+1)); // R2
  AST_TRUNC_ONE: assert property (@(posedge clk) disable iff (!rst_n) (start && mode == 2'd2 && trange == VAL_W'(1)) |=> (len == LEN_W'(1) && !err)); // R4
endmodule

// File: tb/tb_expg_decode.sv
module tb_expg_decode;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] win = 0, trange = 0;
  logic [4:0]  lz = 0;
  logic [1:0]  mode = 0;
  logic [31:0] value;
  logic [5:0]  len;
  logic        err, done;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { logic [31:0] v; logic [5:0] l; logic e; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  expg_decode dut (.clk(clk), .rst_n(rst_n), .start(start), .win(win), .lz(lz),
                   .mode(mode), .trange(trange), .value(value), .len(len),
                   .err(err), .done(done));

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic push(input logic [31:0] w, input logic [4:0] z, input logic [1:0] md,
                      input logic [31:0] rg, input logic [31:0] ev, input logic [5:0] el,
                      input logic ee, input string tag);
    exp_t x;
    @(negedge clk);
    start = 1; win = w; lz = z; mode = md; trange = rg;
    x.v = ev; x.l = el; x.e = ee; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic send_code(input int k, input logic [1:0] md, input logic [31:0] rg,
                           input logic [31:0] pad, input string tag);
    int m, n;
    logic [31:0] w, ev;
    m = $clog2(k + 2) - 1;
    n = 2 * m + 1;
    w = (32'(k + 1) << (32 - n)) | (pad >> n);
    if (md == 2'd1) ev = (k % 2 == 1) ? 32'((k + 1) / 2) : -32'(k / 2);
    else ev = 32'(k);
    push(w, 5'(m), md, rg, ev, 6'(n), 1'b0, tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    start = 0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t x;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected done: actual done=1 expected done=0");
      end else begin
        x = q.pop_front();
        if (value !== x.v || len !== x.l || err !== x.e) begin
          errors++;
          $display("FAIL %s: actual value=%0h len=%0d err=%0b expected value=%0h len=%0d err=%0b",
                   x.tag, value, len, err, x.v, x.l, x.e);
        end
      end
    end
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] held_v;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 0 || err !== 0 || len !== 0 || value !== 0) begin
      errors++;
      $display("FAIL R8 reset: actual done=%0b err=%0b len=%0d value=%0h expected all 0",
               done, err, len, value);
    end
    rst_n = 1;
    @(negedge clk);

    for (int m = 0; m <= 15; m++) begin
      send_code((1 << m) - 1, 2'd0, 0, 32'hFFFF_FFFF, "R1 R2 min code");
      send_code((1 << (m + 1)) - 2, 2'd0, 0, 32'h0, "R1 R2 max code");
    end
    send_code(5, 2'd3, 0, 32'hA5A5_A5A5, "R1 mode3 unsigned");
    send_code(0, 2'd1, 0, 32'h7FFF_FFFF, "R3 signed zero");
    send_code(1, 2'd1, 0, 32'h0, "R3 signed +1");
    send_code(2, 2'd1, 0, 32'hFFFF_FFFF, "R3 signed -1");
    send_code(7, 2'd1, 0, 32'h1234_5678, "R3 signed +4");
    send_code(8, 2'd1, 0, 32'h1234_5678, "R3 signed -4");
    send_code(65534, 2'd1, 0, 32'h0, "R3 signed large even");
    push(32'h8000_0000, 5'd7, 2'd2, 1, 32'd0, 6'd1, 1'b0, "R4 trunc bit 1");
    push(32'h7FFF_FFFF, 5'd3, 2'd2, 1, 32'd1, 6'd1, 1'b0, "R4 trunc bit 0");
    send_code(2, 2'd2, 2, 32'hFFFF_FFFF, "R5 trunc range 2");
    send_code(9, 2'd2, 40, 32'h0, "R5 trunc range 40");
    push(32'h0000_0000, 5'd16, 2'd0, 0, 32'd0, 6'd0, 1'b1, "R6 lz too big");
    push(32'h0800_0000, 5'd3, 2'd1, 0, 32'd0, 6'd0, 1'b1, "R6 no one at lz");
    push(32'h0000_0000, 5'd31, 2'd2, 5, 32'd0, 6'd0, 1'b1, "R6 empty window");
    send_code(3, 2'd0, 0, 32'h0, "R7 last before idle");
    idle(1);
    held_v = value;
    for (int i = 0; i < 5; i++) begin
      checks++;
      if (done !== 0 || value !== held_v || len !== 6'd5) begin
        errors++;
        $display("FAIL R7 idle hold: actual done=%0b value=%0h len=%0d expected done=0 value=%0h len=5",
                 done, value, len, held_v);
      end
      @(negedge clk);
    end
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R7 missing done: actual pending=%0d expected 0", q.size());
    end
    summary();
  end
endmodule